// File: doc/BRIEF.md
# Page-List Segment Walker

This block turns a host buffer description into an ordered stream of memory segments. The buffer is given as two 64-bit page pointers, a byte count and a page-size code. The first pointer may point into the middle of a page. The second pointer is used in one of two ways. When no more than one page of data is left after the first segment, it is a data page. Otherwise it points to a list of 64-bit page pointers held in host memory. The walker reads that list one entry at a time through a simple request/response read port.

A list page holds page_size / 8 entries. When more than one page of data is still left at the last slot of a list page, that slot holds a pointer to the next list page rather than a data page. The walker follows it and restarts its slot count at zero. Every pointer is checked, and the walk ends with exactly one pulse: done if the buffer was described in full, or err if it was not. Segments are offered on a valid/ready handshake, so a consumer can stall the walker at any time.

Top module: `prp_walker`

## Requirements
- R1: The page size is 2^(12 + m) bytes, where m is the page-size code latched at start, clamped to MAX_MPS. The first segment starts at ptr1 and is min(len, page_size - (ptr1 mod page_size)) bytes long.
- R2: Every failed walk ends with err high for one cycle and err_status equal to 16'h4002. Bits 7:0 hold the invalid-field code 8'h02 and bit 14 is the do-not-retry flag. A zero ptr1 fails before any segment is offered.
- R3: A walk with a non-zero ptr1 and a length of zero ends in done, with no segment offered and no list read.
- R4: If bytes remain after the first segment and ptr2 is zero, the walk fails once the first segment has been accepted.
- R5: If the bytes left after the first segment fit in one page, ptr2 is offered as a single segment of exactly that many bytes, with no list read. A ptr2 that is not page aligned fails the walk instead.
- R6: If more than one page remains, the list starts at ptr2, which may be unaligned. Slot i is read at list_base + 8*i. For each list page the walker reads min(page_size/8, ceil(remaining/page_size)) entries, counting the remaining bytes at the moment that list page is entered. The read data carries the byte at the lowest address in bits 7:0, so each entry is the 64-bit word exactly as returned.
- R7: Each data entry must be non-zero and page aligned. A valid entry yields a segment of min(remaining, page_size) bytes. A bad entry fails the walk. A segment is never offered with zero length.
- R8: At the last slot of a list page, the entry is a chain pointer only when more than one page remains. A chain pointer must be non-zero and page aligned, and the walker then restarts at slot 0 of the page it names. When one page or less remains at that slot, the entry is read as a data page.
- R9: Segments come out in buffer order. A segment that is offered but not accepted holds its address and length until seg_ready is seen.
- R10: A list read request holds rd_req_valid and its address until rd_req_ready is seen, and the requests come in slot order.
- R11: Each walk ends with exactly one done or err pulse, never both. The pulse comes only after every segment has been accepted, and busy is low in that cycle. After reset the block is idle and drives no request or segment.
- R12: A start pulse while busy is high is ignored, and the walk in progress finishes with its original parameters.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | Begins a walk with the pointer, length and size inputs when idle |
| ptr1 | input | ADDR_W | First page pointer, may carry an in-page offset |
| ptr2 | input | ADDR_W | Second pointer: data page or list address |
| xfer_len | input | LEN_W | Buffer length in bytes |
| mps | input | MPS_W | Page-size code, page = 2^(12+mps) |
| busy | output | 1 | A walk is in progress |
| seg_valid | output | 1 | A segment is offered |
| seg_ready | input | 1 | Consumer accepts the offered segment |
| seg_addr | output | ADDR_W | Segment start address |
| seg_len | output | LEN_W | Segment length in bytes |
| rd_req_valid | output | 1 | List entry read request |
| rd_req_ready | input | 1 | Memory accepts the read request |
| rd_req_addr | output | ADDR_W | Address of the 8-byte list entry |
| rd_rsp_valid | input | 1 | Read data returned |
| rd_rsp_data | input | 64 | Returned list entry |
| done | output | 1 | One-cycle pulse: walk completed |
| err | output | 1 | One-cycle pulse: walk failed |
| err_status | output | 16 | Failure status, valid with err |

## Verification
The segment register runs apart from the list fetcher, so one edge can both hand over a segment and launch the read for the next list slot. To make that happen, the bench pulls seg_ready low in a repeating pattern and throttles rd_req_ready on a different rhythm during the multi-entry and chained walks. The two handshakes therefore line up on some edges and miss each other on others. The scoreboard judges the result against a queue of expected segments and a queue of expected read addresses, both built from the requirements. Any slip in order, length or address shows up as a mismatch, and so does a done or err that arrives before the last segment is taken.

// File: rtl/prp_walk_pkg.sv
package prp_walk_pkg;

  localparam int ENT_W = 64;

  // invalid field code with the do-not-retry flag in bit 14
  localparam logic [15:0] ST_BAD_FIELD = 16'h4002;

  typedef enum logic [2:0] {
    W_IDLE,
    W_FIRST,
    W_SECOND,
    W_REQ,
    W_WAIT,
    W_PROC,
    W_FINISH,
    W_FAIL
  } walk_state_e;

endpackage

// File: rtl/prp_page_geom.sv
module prp_page_geom #(
  parameter int ADDR_W  = 64,
  parameter int LEN_W   = 32,
  parameter int MPS_W   = 3,
  parameter int MAX_MPS = 4,
  parameter int IDX_W   = MAX_MPS + 10
) (
  input  logic [MPS_W-1:0]  mps,
  input  logic [ADDR_W-1:0] ptr,
  input  logic [LEN_W-1:0]  len,
  output logic [LEN_W-1:0]  page_bytes,
  output logic [ADDR_W-1:0] page_mask,
  output logic [IDX_W-1:0]  last_slot,
  output logic [LEN_W-1:0]  first_len
);

  localparam logic [MPS_W-1:0] MPS_CAP = MPS_W'(MAX_MPS);

  logic [MPS_W-1:0] eff_mps;
  logic [LEN_W-1:0] in_page_off;
  logic [LEN_W-1:0] room;

  always_comb begin
    eff_mps     = (mps > MPS_CAP) ? MPS_CAP : mps;
    page_bytes  = {{(LEN_W-1){1'b0}}, 1'b1} << (32'(eff_mps) + 32'd12);
    page_mask   = ADDR_W'(page_bytes) - ADDR_W'(1);
    last_slot   = IDX_W'(page_bytes >> 3) - IDX_W'(1);
    in_page_off = LEN_W'(ptr & page_mask);
    room        = page_bytes - in_page_off;
    first_len   = (len < room) ? len : room;
  end

endmodule

// File: rtl/prp_seg_slot.sv
module prp_seg_slot #(
  parameter int ADDR_W = 64,
  parameter int LEN_W  = 32
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              load,
  input  logic [ADDR_W-1:0] ld_addr,
  input  logic [LEN_W-1:0]  ld_len,
  input  logic              ready,
  output logic              valid,
  output logic [ADDR_W-1:0] addr,
  output logic [LEN_W-1:0]  len,
  output logic              free
);

  assign free = !valid || ready;

  always_ff @(posedge clk) begin
    if (rst) begin
      valid <= 1'b0;
      addr  <= '0;
      len   <= '0;
    end else if (load) begin
      valid <= 1'b1;
      addr  <= ld_addr;
      len   <= ld_len;
    end else if (ready) begin
      valid <= 1'b0;
    end
  end

endmodule

// File: rtl/prp_entry_fetch.sv
module prp_entry_fetch #(
  parameter int ADDR_W = 64,
  parameter int ENT_W  = 64
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              issue,
  input  logic [ADDR_W-1:0] issue_addr,
  output logic              rq_valid,
  input  logic              rq_ready,
  output logic [ADDR_W-1:0] rq_addr,
  input  logic              rs_valid,
  input  logic [ENT_W-1:0]  rs_data,
  output logic              ent_valid,
  output logic [ENT_W-1:0]  ent_data
);

  always_ff @(posedge clk) begin
    if (rst) begin
      rq_valid  <= 1'b0;
      rq_addr   <= '0;
      ent_valid <= 1'b0;
      ent_data  <= '0;
    end else begin
      if (issue) begin
        rq_valid <= 1'b1;
        rq_addr  <= issue_addr;
      end else if (rq_valid && rq_ready) begin
        rq_valid <= 1'b0;
      end
      ent_valid <= rs_valid;
      if (rs_valid) begin
        ent_data <= rs_data;
      end
    end
  end

endmodule

// File: rtl/prp_walker.sv
module prp_walker
  import prp_walk_pkg::*;
#(
  parameter int ADDR_W  = 64,
  parameter int LEN_W   = 32,
  parameter int MPS_W   = 3,
  parameter int MAX_MPS = 4
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-1:0] ptr1,
  input  logic [ADDR_W-1:0] ptr2,
  input  logic [LEN_W-1:0]  xfer_len,
  input  logic [MPS_W-1:0]  mps,
  output logic              busy,
  output logic              seg_valid,
  input  logic              seg_ready,
  output logic [ADDR_W-1:0] seg_addr,
  output logic [LEN_W-1:0]  seg_len,
  output logic              rd_req_valid,
  input  logic              rd_req_ready,
  output logic [ADDR_W-1:0] rd_req_addr,
  input  logic              rd_rsp_valid,
  input  logic [63:0]       rd_rsp_data,
  output logic              done,
  output logic              err,
  output logic [15:0]       err_status
);

  localparam int IDX_W = MAX_MPS + 10;

  walk_state_e       state;
  logic [ADDR_W-1:0] p1_q, p2_q, base_q;
  logic [LEN_W-1:0]  rem_q;
  logic [MPS_W-1:0]  mps_q;
  logic [IDX_W-1:0]  idx_q;
  logic              done_q, err_q;
  logic [15:0]       status_q;

  logic [LEN_W-1:0]  page_bytes, first_len, data_len;
  logic [ADDR_W-1:0] page_mask, ent_addr, fetch_addr;
  logic [IDX_W-1:0]  last_slot;
  logic              rem_gt_page, p2_misaligned, ent_bad, is_chain;

  logic              seg_load, seg_free;
  logic [ADDR_W-1:0] seg_ld_addr;
  logic [LEN_W-1:0]  seg_ld_len;
  logic              fetch_issue, ent_valid;
  logic [ENT_W-1:0]  ent_data;

  prp_page_geom #(
    .ADDR_W(ADDR_W), .LEN_W(LEN_W), .MPS_W(MPS_W),
    .MAX_MPS(MAX_MPS), .IDX_W(IDX_W)
  ) u_geom (
    .mps(mps_q), .ptr(p1_q), .len(rem_q),
    .page_bytes(page_bytes), .page_mask(page_mask),
    .last_slot(last_slot), .first_len(first_len)
  );

  prp_seg_slot #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_slot (
    .clk(clk), .rst(rst), .load(seg_load),
    .ld_addr(seg_ld_addr), .ld_len(seg_ld_len), .ready(seg_ready),
    .valid(seg_valid), .addr(seg_addr), .len(seg_len), .free(seg_free)
  );

  prp_entry_fetch #(.ADDR_W(ADDR_W), .ENT_W(ENT_W)) u_fetch (
    .clk(clk), .rst(rst), .issue(fetch_issue), .issue_addr(fetch_addr),
    .rq_valid(rd_req_valid), .rq_ready(rd_req_ready), .rq_addr(rd_req_addr),
    .rs_valid(rd_rsp_valid), .rs_data(rd_rsp_data),
    .ent_valid(ent_valid), .ent_data(ent_data)
  );

  always_comb begin
    ent_addr      = ADDR_W'(ent_data);
    rem_gt_page   = rem_q > page_bytes;
    data_len      = rem_gt_page ? page_bytes : rem_q;
    p2_misaligned = (p2_q & page_mask) != '0;
    ent_bad       = (ent_addr == '0) || ((ent_addr & page_mask) != '0);
    is_chain      = (idx_q == last_slot) && rem_gt_page;
    fetch_addr    = base_q + (ADDR_W'(idx_q) << 3);
  end

  always_comb begin
    seg_load    = 1'b0;
    seg_ld_addr = '0;
    seg_ld_len  = '0;
    fetch_issue = 1'b0;
    case (state)
      W_FIRST: begin
        if (p1_q != '0 && rem_q != '0 && seg_free) begin
          seg_load    = 1'b1;
          seg_ld_addr = p1_q;
          seg_ld_len  = first_len;
        end
      end
      W_SECOND: begin
        if (rem_q != '0 && p2_q != '0 && !rem_gt_page && !p2_misaligned && seg_free) begin
          seg_load    = 1'b1;
          seg_ld_addr = p2_q;
          seg_ld_len  = rem_q;
        end
      end
      W_REQ: fetch_issue = 1'b1;
      W_PROC: begin
        if (!ent_bad && !is_chain && seg_free) begin
          seg_load    = 1'b1;
          seg_ld_addr = ent_addr;
          seg_ld_len  = data_len;
        end
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state    <= W_IDLE;
      p1_q     <= '0;
      p2_q     <= '0;
      base_q   <= '0;
      rem_q    <= '0;
      mps_q    <= '0;
      idx_q    <= '0;
      done_q   <= 1'b0;
      err_q    <= 1'b0;
      status_q <= '0;
    end else begin
      done_q <= 1'b0;
      err_q  <= 1'b0;
      case (state)
        W_IDLE: begin
          if (start) begin
            p1_q  <= ptr1;
            p2_q  <= ptr2;
            rem_q <= xfer_len;
            mps_q <= mps;
            idx_q <= '0;
            state <= W_FIRST;
          end
        end
        W_FIRST: begin
          if (p1_q == '0) begin
            state <= W_FAIL;
          end else if (rem_q == '0) begin
            state <= W_FINISH;
          end else if (seg_free) begin
            rem_q <= rem_q - first_len;
            state <= W_SECOND;
          end
        end
        W_SECOND: begin
          if (rem_q == '0) begin
            state <= W_FINISH;
          end else if (p2_q == '0) begin
            state <= W_FAIL;
          end else if (!rem_gt_page) begin
            if (p2_misaligned) begin
              state <= W_FAIL;
            end else if (seg_free) begin
              rem_q <= '0;
              state <= W_FINISH;
            end
          end else begin
            base_q <= p2_q;
            idx_q  <= '0;
            state  <= W_REQ;
          end
        end
        W_REQ: state <= W_WAIT;
        W_WAIT: begin
          if (ent_valid) begin
            state <= W_PROC;
          end
        end
        W_PROC: begin
          if (ent_bad) begin
            state <= W_FAIL;
          end else if (is_chain) begin
            base_q <= ent_addr;
            idx_q  <= '0;
            state  <= W_REQ;
          end else if (seg_free) begin
            rem_q <= rem_q - data_len;
            idx_q <= idx_q + IDX_W'(1);
            state <= (rem_q == data_len) ? W_FINISH : W_REQ;
          end
        end
        W_FINISH: begin
          if (!seg_valid) begin
            done_q <= 1'b1;
            state  <= W_IDLE;
          end
        end
        W_FAIL: begin
          if (!seg_valid) begin
            err_q    <= 1'b1;
            status_q <= ST_BAD_FIELD;
            state    <= W_IDLE;
          end
        end
        default: state <= W_IDLE;
      endcase
    end
  end

  assign busy       = (state != W_IDLE);
  assign done       = done_q;
  assign err        = err_q;
  assign err_status = status_q;

endmodule

// File: rtl/prp_walker_chk.sv
module prp_walker_chk #(
  parameter int ADDR_W = 64,
  parameter int LEN_W  = 32
) (
  input logic              clk,
  input logic              rst,
  input logic              busy,
  input logic              seg_valid,
  input logic              seg_ready,
  input logic [ADDR_W-1:0] seg_addr,
  input logic [LEN_W-1:0]  seg_len,
  input logic              rd_req_valid,
  input logic              rd_req_ready,
  input logic [ADDR_W-1:0] rd_req_addr,
  input logic              done,
  input logic              err,
  input logic [15:0]       err_status
);

  AST_SEG_HOLD: assert property (@(posedge clk) disable iff (rst)
    (seg_valid && !seg_ready) |=> (seg_valid && $stable(seg_addr) && $stable(seg_len))); // R9

  AST_REQ_HOLD: assert property (@(posedge clk) disable iff (rst)
    (rd_req_valid && !rd_req_ready) |=> (rd_req_valid && $stable(rd_req_addr))); // R10

  AST_SEG_NONEMPTY: assert property (@(posedge clk) disable iff (rst)
    seg_valid |-> (seg_len != '0)); // R7

  AST_ONE_OUTCOME: assert property (@(posedge clk) disable iff (rst)
    !(done && err)); // R11

  AST_END_DRAINED: assert property (@(posedge clk) disable iff (rst)
    (done || err) |-> (!seg_valid && !busy)); // R11

  AST_ERR_CODE: assert property (@(posedge clk) disable iff (rst)
    err |-> (err_status == 16'h4002)); // R2

endmodule

bind prp_walker prp_walker_chk #(.ADDR_W(ADDR_W), .LEN_W(LEN_W)) u_chk (
  .clk(clk), .rst(rst), .busy(busy),
  .seg_valid(seg_valid), .seg_ready(seg_ready), .seg_addr(seg_addr), .seg_len(seg_len),
  .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready), .rd_req_addr(rd_req_addr),
  .done(done), .err(err), .err_status(err_status)
);

// File: tb/tb_prp_walker.sv
module tb_prp_walker;

  localparam int ADDR_W  = 64;
  localparam int LEN_W   = 32;
  localparam int MPS_W   = 3;
  localparam int MAX_MPS = 4;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              start = 1'b0;
  logic [ADDR_W-1:0] ptr1 = '0, ptr2 = '0;
  logic [LEN_W-1:0]  xfer_len = '0;
  logic [MPS_W-1:0]  mps = '0;
  logic              busy, seg_valid, seg_ready = 1'b1;
  logic [ADDR_W-1:0] seg_addr, rd_req_addr;
  logic [LEN_W-1:0]  seg_len;
  logic              rd_req_valid, rd_req_ready = 1'b1;
  logic              rd_rsp_valid = 1'b0;
  logic [63:0]       rd_rsp_data = '0;
  logic              done, err;
  logic [15:0]       err_status;

  always #2 clk = ~clk;

  prp_walker #(.ADDR_W(ADDR_W), .LEN_W(LEN_W), .MPS_W(MPS_W), .MAX_MPS(MAX_MPS)) dut (
    .clk(clk), .rst(rst), .start(start), .ptr1(ptr1), .ptr2(ptr2),
    .xfer_len(xfer_len), .mps(mps), .busy(busy),
    .seg_valid(seg_valid), .seg_ready(seg_ready), .seg_addr(seg_addr), .seg_len(seg_len),
    .rd_req_valid(rd_req_valid), .rd_req_ready(rd_req_ready), .rd_req_addr(rd_req_addr),
    .rd_rsp_valid(rd_rsp_valid), .rd_rsp_data(rd_rsp_data),
    .done(done), .err(err), .err_status(err_status)
  );

  typedef struct {
    logic [63:0] a;
    logic [31:0] l;
  } seg_t;

  int checks = 0;
  int errors = 0;
  seg_t exp_segs[$];
  logic [63:0] exp_reads[$];
  logic [63:0] mem [logic [63:0]];
  bit bp_seg = 0, bp_rd = 0;
  int done_cnt = 0, err_cnt = 0;
  logic [15:0] last_status = '0;
  int cyc = 0;
  int rsp_wait = 0;
  logic [63:0] rsp_hold = '0;

  task automatic check(input bit ok, input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  function automatic logic [63:0] rd_mem(input logic [63:0] a);
    return mem.exists(a) ? mem[a] : 64'h0;
  endfunction

  task automatic fill_list(input logic [63:0] base, input int n,
                           input logic [63:0] data_base, input logic [63:0] ps);
    for (int i = 0; i < n; i++) mem[base + 64'(i) * 8] = data_base + 64'(i) * ps;
  endtask

  task automatic push_seg(input logic [63:0] a, input logic [63:0] l);
    seg_t s;
    s.a = a;
    s.l = l[31:0];
    exp_segs.push_back(s);
  endtask

  // expected behaviour built from the requirements
  task automatic model(input logic [63:0] p1, input logic [63:0] p2, input logic [63:0] len,
                       input int m, output bit fail);
    logic [63:0] ps, mask, first, rem, base, e, l;
    int i, ents;
    fail = 0;
    ps   = 64'd1 << (12 + ((m > MAX_MPS) ? MAX_MPS : m));
    mask = ps - 1;
    ents = int'(ps / 8);
    if (p1 == 0) begin fail = 1; return; end
    if (len == 0) return;
    first = ps - (p1 & mask);
    if (len < first) first = len;
    push_seg(p1, first);
    rem = len - first;
    if (rem == 0) return;
    if (p2 == 0) begin fail = 1; return; end
    if (rem <= ps) begin
      if ((p2 & mask) != 0) begin fail = 1; return; end
      push_seg(p2, rem);
      return;
    end
    base = p2;
    i = 0;
    while (rem > 0) begin
      exp_reads.push_back(base + 64'(i) * 8);
      e = rd_mem(base + 64'(i) * 8);
      if (e == 0 || (e & mask) != 0) begin fail = 1; return; end
      if (i == ents - 1 && rem > ps) begin
        base = e;
        i = 0;
      end else begin
        l = (rem > ps) ? ps : rem;
        push_seg(e, l);
        rem = rem - l;
        i++;
      end
    end
  endtask

  // monitor, scoreboard and memory responder, all at the falling edge
  initial begin
    forever begin
      @(negedge clk);
      cyc++;
      seg_ready = bp_seg ? ((cyc % 3) != 0) : 1'b1;
      if (seg_valid && seg_ready) begin
        if (exp_segs.size() == 0) begin
          check(0, "R9", "unexpected segment addr", seg_addr, 64'h0);
        end else begin
          seg_t s;
          s = exp_segs.pop_front();
          check(seg_addr == s.a, "R9", "segment address", seg_addr, s.a);
          check(seg_len == s.l, "R7", "segment length", 64'(seg_len), 64'(s.l));
        end
      end
      if (done) done_cnt++;
      if (err) begin
        err_cnt++;
        last_status = err_status;
      end
      rd_rsp_valid = 1'b0;
      if (rsp_wait > 0) begin
        rsp_wait--;
        if (rsp_wait == 0) begin
          rd_rsp_valid = 1'b1;
          rd_rsp_data  = rsp_hold;
        end
      end
      rd_req_ready = bp_rd ? ((cyc % 4) != 1) : 1'b1;
      if (rd_req_valid && rd_req_ready) begin
        if (exp_reads.size() == 0) begin
          check(0, "R6", "unexpected list read", rd_req_addr, 64'h0);
        end else begin
          logic [63:0] ea;
          ea = exp_reads.pop_front();
          check(rd_req_addr == ea, "R10", "list read address", rd_req_addr, ea);
        end
        rsp_hold = rd_mem(rd_req_addr);
        rsp_wait = 2;
      end
    end
  end

  task automatic run_walk(input string req, input logic [63:0] p1, input logic [63:0] p2,
                          input logic [63:0] len, input int m, input bit poke);
    bit fail;
    int t;
    exp_segs.delete();
    exp_reads.delete();
    model(p1, p2, len, m, fail);
    done_cnt = 0;
    err_cnt  = 0;
    @(negedge clk);
    ptr1 = p1; ptr2 = p2; xfer_len = len[31:0]; mps = MPS_W'(m);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    ptr1 = '0; ptr2 = '0; xfer_len = '0;
    if (poke) begin
      repeat (6) @(negedge clk);
      ptr1 = 64'hdead_0000; ptr2 = 64'h0; xfer_len = 32'h10; mps = '0;
      start = 1'b1;       // R12: must be ignored while busy
      @(negedge clk);
      start = 1'b0;
    end
    t = 0;
    while (done_cnt + err_cnt == 0 && t < 40000) begin
      @(negedge clk);
      t++;
    end
    repeat (4) @(negedge clk);
    check(t < 40000, req, "walk timed out", 64'(t), 64'd40000);
    check(err_cnt == int'(fail), req, "error pulse count", 64'(err_cnt), 64'(fail));
    check(done_cnt == int'(!fail), "R11", "done pulse count", 64'(done_cnt), 64'(!fail));
    check(exp_segs.size() == 0, req, "segments still expected", 64'(exp_segs.size()), 64'd0);
    check(exp_reads.size() == 0, "R6", "list reads still expected", 64'(exp_reads.size()), 64'd0);
    if (fail) check(last_status == 16'h4002, "R2", "error status", 64'(last_status), 64'h4002);
    check(!busy, "R11", "idle after walk", 64'(busy), 64'd0);
  endtask

  initial begin
    repeat (190000) @(posedge clk);
    checks++;
    errors++;
    $display("FAIL R11 watchdog actual=running expected=finished");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (4) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check(!busy && !seg_valid && !rd_req_valid && !done && !err, "R11", "reset state",
          {59'd0, busy, seg_valid, rd_req_valid, done, err}, 64'd0);

    // R2: null first pointer
    run_walk("R2", 64'h0, 64'h2000_0000, 64'h200, 0, 0);
    // R3: zero length
    run_walk("R3", 64'h1000_0000, 64'h0, 64'h0, 0, 0);
    // R1: single segment inside a page
    run_walk("R1", 64'h1000_0100, 64'h0, 64'h200, 0, 0);
    // R5: crossing into a direct second page
    run_walk("R5", 64'h1000_0F00, 64'h2000_0000, 64'h300, 0, 0);
    // R4: second pointer missing
    run_walk("R4", 64'h1000_0F00, 64'h0, 64'h300, 0, 0);
    // R5: misaligned direct second page
    run_walk("R5", 64'h1000_0F00, 64'h2000_0040, 64'h300, 0, 0);
    // R1: code above the cap behaves as the cap (64 KiB page)
    run_walk("R1", 64'h0001_0100, 64'h0009_0000, 64'h1_0000, 7, 0);

    // R6: list of four pages with backpressure on both ports
    bp_seg = 1; bp_rd = 1;
    fill_list(64'h3000_0000, 4, 64'h4000_0000, 64'd8192);
    run_walk("R6", 64'h1000_0000, 64'h3000_0000, 64'd5 * 8192, 1, 0);
    // R6: unaligned list base and partial first/last pages
    fill_list(64'h5500_0010, 4, 64'h4100_0000, 64'd4096);
    run_walk("R6", 64'h0200_0800, 64'h5500_0010, 64'd4 * 4096, 0, 0);
    // R7: misaligned data entry
    fill_list(64'h5400_0000, 4, 64'h4200_0000, 64'd4096);
    mem[64'h5400_0010] = 64'h4200_0010;
    run_walk("R7", 64'h1000_0000, 64'h5400_0000, 64'd5 * 4096, 0, 0);
    bp_seg = 0; bp_rd = 0;

    // R8: chain to a second list page, start pulse while busy (R12)
    fill_list(64'h5000_0000, 511, 64'h6000_0000, 64'd4096);
    mem[64'h5000_0000 + 511 * 8] = 64'h5100_0000;
    fill_list(64'h5100_0000, 3, 64'h7000_0000, 64'd4096);
    bp_seg = 1;
    run_walk("R8", 64'h0100_0000, 64'h5000_0000, 64'd515 * 4096, 0, 1);
    bp_seg = 0;
    // R12 is judged by the same walk finishing as modelled
    check(done_cnt == 1, "R12", "walk unchanged by start while busy", 64'(done_cnt), 64'd1);
    // R8: exactly one page left at the last slot is data
    fill_list(64'h5200_0000, 512, 64'h6800_0000, 64'd4096);
    run_walk("R8", 64'h0100_0000, 64'h5200_0000, 64'd513 * 4096, 0, 0);
    // R8: null chain pointer
    fill_list(64'h5300_0000, 511, 64'h6c00_0000, 64'd4096);
    run_walk("R8", 64'h0100_0000, 64'h5300_0000, 64'd515 * 4096, 0, 0);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule